// File: doc/BRIEF.md
# Serial ADC Readout Receiver

This block sits on the host side of a 12-bit converter that is used in its serial-output mode. When asked, it pulls the converter's read/convert line low for a fixed number of clock cycles. The converter then drives its own data clock and serial data line, and holds BUSY low until both the conversion and the serial transfer have finished. The receiver passes the data clock, the data line and BUSY through two-flop synchronisers and samples the data on each detected rising edge of the data clock. When BUSY returns high, it checks how many bits arrived.

The bits shifted out during conversion n hold the result of conversion n-1. The receiver therefore numbers the conversions it starts and tags each reported word with the index of the sample the word belongs to. The burst of the first conversion after reset holds nothing useful and is dropped. A burst with the wrong number of clock edges raises a one-cycle framing-error flag in place of a sample. The receiver drops convert requests while a conversion is in flight, while BUSY is low, or before the minimum spacing since the previous start has passed.

Top module: `sadc_rx`

## Requirements
- R1: An accepted request drives `adc_conv_n` low starting in the cycle after acceptance, and holds it low for exactly PULSE_CYC cycles (default 3).
- R2: The receiver drops a `conv_req` that arrives while a conversion is in flight (from acceptance until BUSY returns high) or while the synchronised BUSY is low. A dropped request is not queued.
- R3: The receiver drops a `conv_req` that arrives fewer than SPACE_CYC cycles after the previous accepted request.
- R4: Bits are taken on synchronised rising edges of `adc_dclk`, the first received bit being the MSB. `smp_data` is the 12-bit word read as two's complement, so 0x800 is -2048 and 0x7FF is +2047.
- R5: When BUSY rises after exactly 12 rising data clock edges, `smp_valid` is high for exactly one cycle, the cycle after the synchronised BUSY rise, together with the word.
- R6: Conversions are numbered from 0 after reset. The word received in the burst of conversion k carries `smp_index` = k-1, modulo 2^IDX_W.
- R7: The burst of conversion 0 after reset produces neither `smp_valid` nor `frame_err`.
- R8: A burst with any rising-edge count other than 12 (including 0) produces a one-cycle `frame_err` and no `smp_valid`. Its sample index is used up.
- R9: During reset `adc_conv_n` is high, `smp_valid` and `frame_err` are low, and `smp_data` and `smp_index` are zero.
- R10: Data clock edges that arrive while no conversion is in flight have no effect on the next reported word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_req | input | 1 | Request to start a conversion |
| adc_conv_n | output | 1 | Read/convert line to converter, active low |
| adc_busy | input | 1 | Converter BUSY, low during conversion and transfer (asynchronous) |
| adc_dclk | input | 1 | Converter-driven data clock (asynchronous) |
| adc_sdata | input | 1 | Converter serial data (asynchronous) |
| smp_valid | output | 1 | One-cycle pulse: new sample available |
| smp_data | output | 12 | Signed sample |
| smp_index | output | IDX_W (16) | Index of the sample carried by `smp_data` |
| frame_err | output | 1 | One-cycle pulse: burst had the wrong bit count |

## Verification
The hardest case to reach is the one-sample offset between conversions and the words they carry, especially when it meets framing errors and the discarded first burst. The bench models the converter's serial side. It counts every conversion it sees start, so a short or long burst still uses up an index. A seeded random run mixes 12-edge bursts with 11- and 13-edge bursts. Directed cases add the extreme signed codes, an empty burst, stray data clock edges while idle, and convert requests issued during BUSY low and inside the spacing window.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  localparam int unsigned SADC_BITS = 12;

  typedef enum logic [1:0] {
    CV_IDLE  = 2'd0,
    CV_PULSE = 2'd1,
    CV_WAIT  = 2'd2,
    CV_XFER  = 2'd3
  } cv_state_t;

  // A burst is complete only when the edge count matches the word width.
  function automatic logic burst_complete(input int unsigned seen,
                                          input int unsigned want);
    return seen == want;
  endfunction

  // Sample tag for a burst: the previous conversion's number.
  function automatic logic [31:0] prior_index(input logic [31:0] conv_num);
    return conv_num - 32'd1;
  endfunction

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST_VAL;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sadc_conv_ctrl.sv
module sadc_conv_ctrl
  import sadc_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned SPACE_CYC = 1250,
  parameter int unsigned IDX_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_req,
  input  logic             busy_s,
  output logic             conv_n,
  output logic             active,
  output logic             start,
  output logic             busy_rise,
  output logic             done,
  output logic [IDX_W-1:0] conv_num
);

  localparam int unsigned PW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC);
  localparam int unsigned GW = $clog2(SPACE_CYC + 1);

  cv_state_t      state;
  logic [PW-1:0]  pcnt;
  logic [GW-1:0]  gap;
  logic           busy_q;
  logic [IDX_W-1:0] next_num;
  logic           gap_ok;

  assign gap_ok    = (gap >= GW'(SPACE_CYC));
  assign start     = (state == CV_IDLE) && conv_req && busy_s && gap_ok;
  assign busy_rise = busy_s && !busy_q;
  assign done      = (state == CV_XFER) && busy_rise;
  assign active    = (state != CV_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b1;
    else        busy_q <= busy_s;
  end

  // Spacing counter: distance in cycles from the last accepted request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap <= GW'(SPACE_CYC);
    else if (start)   gap <= GW'(1);
    else if (!gap_ok) gap <= gap + GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CV_IDLE;
      pcnt     <= '0;
      conv_n   <= 1'b1;
      conv_num <= '0;
      next_num <= '0;
    end else begin
      case (state)
        CV_IDLE: begin
          if (start) begin
            state    <= CV_PULSE;
            conv_n   <= 1'b0;
            pcnt     <= PW'(PULSE_CYC - 1);
            conv_num <= next_num;
            next_num <= next_num + IDX_W'(1);
          end
        end
        CV_PULSE: begin
          if (pcnt == '0) begin
            conv_n <= 1'b1;
            state  <= CV_WAIT;
          end else begin
            pcnt <= pcnt - PW'(1);
          end
        end
        CV_WAIT: begin
          if (!busy_s) state <= CV_XFER;
        end
        CV_XFER: begin
          if (busy_rise) state <= CV_IDLE;
        end
        default: state <= CV_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sadc_deser.sv
module sadc_deser #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic              dclk_s,
  input  logic              sdata_s,
  output logic              dclk_rise,
  output logic              bit_take,
  output logic [DATA_W-1:0] word,
  output logic [CNT_W-1:0]  edges
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic dclk_q;

  assign dclk_rise = dclk_s && !dclk_q;
  assign bit_take  = dclk_rise && active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dclk_q <= 1'b0;
    else        dclk_q <= dclk_s;
  end

  // MSB arrives first: shift left, new bit enters at the bottom.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      edges <= '0;
    end else if (start) begin
      word  <= '0;
      edges <= '0;
    end else if (bit_take) begin
      word <= {word[DATA_W-2:0], sdata_s};
      if (edges != CNT_MAX) edges <= edges + CNT_W'(1);
    end
  end

endmodule

// File: rtl/sadc_rx.sv
module sadc_rx
  import sadc_pkg::*;
#(
  parameter int unsigned DATA_W      = SADC_BITS,
  parameter int unsigned IDX_W       = 16,
  parameter int unsigned PULSE_CYC   = 3,
  parameter int unsigned SPACE_CYC   = 1250,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     conv_req,
  output logic                     adc_conv_n,
  input  logic                     adc_busy,
  input  logic                     adc_dclk,
  input  logic                     adc_sdata,
  output logic                     smp_valid,
  output logic signed [DATA_W-1:0] smp_data,
  output logic [IDX_W-1:0]         smp_index,
  output logic                     frame_err
);

  localparam int unsigned CNT_W = $clog2(DATA_W + 2);

  function automatic logic signed [DATA_W-1:0] as_sample(input logic [DATA_W-1:0] w);
    return $signed(w);
  endfunction

  logic [2:0]        sync_q;
  logic              busy_s, dclk_s, sdata_s;
  logic              start, active, busy_rise, burst_done;
  logic              dclk_rise, bit_take;
  logic [IDX_W-1:0]  conv_num;
  logic [DATA_W-1:0] word;
  logic [CNT_W-1:0]  edges;
  logic              first_seen;
  logic              burst_good;
  logic [31:0]       tag_full;

  sadc_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({adc_busy, adc_dclk, adc_sdata}),
    .q    (sync_q)
  );

  assign busy_s  = sync_q[2];
  assign dclk_s  = sync_q[1];
  assign sdata_s = sync_q[0];

  sadc_conv_ctrl #(
    .PULSE_CYC(PULSE_CYC),
    .SPACE_CYC(SPACE_CYC),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv_req (conv_req),
    .busy_s   (busy_s),
    .conv_n   (adc_conv_n),
    .active   (active),
    .start    (start),
    .busy_rise(busy_rise),
    .done     (burst_done),
    .conv_num (conv_num)
  );

  sadc_deser #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_deser (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .active   (active),
    .dclk_s   (dclk_s),
    .sdata_s  (sdata_s),
    .dclk_rise(dclk_rise),
    .bit_take (bit_take),
    .word     (word),
    .edges    (edges)
  );

  assign burst_good = burst_complete(32'(edges), DATA_W);
  assign tag_full   = prior_index(32'(conv_num));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_valid  <= 1'b0;
      frame_err  <= 1'b0;
      smp_data   <= '0;
      smp_index  <= '0;
      first_seen <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      frame_err <= 1'b0;
      if (burst_done) begin
        if (!first_seen) begin
          first_seen <= 1'b1;
        end else if (burst_good) begin
          smp_valid <= 1'b1;
          smp_data  <= as_sample(word);
          smp_index <= tag_full[IDX_W-1:0];
        end else begin
          frame_err <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sadc_rx_chk.sv
module sadc_rx_chk #(
  parameter int unsigned PULSE_CYC = 3,
  parameter int unsigned SPACE_CYC = 1250
) (
  input logic clk,
  input logic rst_n,
  input logic conv_n,
  input logic busy_rise,
  input logic burst_done,
  input logic smp_valid,
  input logic frame_err
);

  localparam int unsigned LW = $clog2(PULSE_CYC + 2);
  localparam int unsigned GW = $clog2(SPACE_CYC + 2);
  localparam logic [LW-1:0] L_MAX = '1;

  logic          conv_q, fell_w, inflight;
  logic [LW-1:0] lo_cnt;
  logic [GW-1:0] gap_c;
  logic [1:0]    done_cnt;

  assign fell_w = conv_q && !conv_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q   <= 1'b1;
      lo_cnt   <= '0;
      inflight <= 1'b0;
      gap_c    <= GW'(SPACE_CYC);
      done_cnt <= '0;
    end else begin
      conv_q <= conv_n;
      if (!conv_n) begin
        if (lo_cnt != L_MAX) lo_cnt <= lo_cnt + LW'(1);
      end else begin
        lo_cnt <= '0;
      end
      if (fell_w)         inflight <= 1'b1;
      else if (busy_rise) inflight <= 1'b0;
      if (fell_w)                         gap_c <= GW'(1);
      else if (gap_c < GW'(SPACE_CYC))    gap_c <= gap_c + GW'(1);
      if (burst_done && done_cnt != 2'd2) done_cnt <= done_cnt + 2'd1;
    end
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_n) |-> lo_cnt == LW'(PULSE_CYC));                       // R1
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    fell_w |-> !inflight);                                             // R2
  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    fell_w |-> gap_c >= GW'(SPACE_CYC));                               // R3
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);                                         // R5
  AST_VALID_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(burst_done));                                  // R5
  AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid || frame_err) |-> done_cnt == 2'd2);                    // R7
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && frame_err));                                        // R8

endmodule

bind sadc_rx sadc_rx_chk #(
  .PULSE_CYC(PULSE_CYC),
  .SPACE_CYC(SPACE_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_n    (adc_conv_n),
  .busy_rise (busy_rise),
  .burst_done(burst_done),
  .smp_valid (smp_valid),
  .frame_err (frame_err)
);

// File: tb/sadc_rx_bench.sv
module sadc_rx_bench;

  localparam int PULSE = 3;
  localparam int SPACE = 400;
  localparam int IDXW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_req = 1'b0;
  logic adc_busy = 1'b1;
  logic adc_dclk = 1'b0;
  logic adc_sdata = 1'b0;
  logic adc_conv_n;
  logic smp_valid, frame_err;
  logic signed [11:0] smp_data;
  logic [IDXW-1:0] smp_index;

  always #10 clk = ~clk;  // 50 MHz

  sadc_rx #(
    .IDX_W(IDXW), .PULSE_CYC(PULSE), .SPACE_CYC(SPACE)
  ) u_sadc_rx (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .adc_conv_n(adc_conv_n),
    .adc_busy(adc_busy), .adc_dclk(adc_dclk), .adc_sdata(adc_sdata),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_index(smp_index),
    .frame_err(frame_err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int conv_k = 0;

  // Monitor of the convert line, sampled away from the active edge.
  int  n_pulses = 0;
  int  last_fell = -100000;
  int  cur_w = 0;
  int  last_w = 0;
  logic prev_cn = 1'b1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (prev_cn && !adc_conv_n) begin
      n_pulses  <= n_pulses + 1;
      last_fell <= cyc;
      cur_w     <= 1;
    end else if (!adc_conv_n) begin
      cur_w <= cur_w + 1;
    end
    if (!prev_cn && adc_conv_n) last_w <= cur_w;
    prev_cn <= adc_conv_n;
  end

  function automatic logic signed [11:0] exp_sample(input logic [11:0] w);
    logic signed [11:0] s;
    s = w;
    return s;
  endfunction

  function automatic logic [IDXW-1:0] exp_index(input int k);
    return IDXW'(k - 1);
  endfunction

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_spacing();
    while (cyc - last_fell <= SPACE + 4) @(negedge clk);
  endtask

  // One full conversion with a modelled converter serial side.
  task automatic burst(input int edges, input logic [11:0] w, input bit poke_busy);
    int got_v, got_e, p0;
    logic signed [11:0] d;
    logic [IDXW-1:0] ix;
    got_v = 0; got_e = 0; d = '0; ix = '0;
    wait_spacing();
    p0 = n_pulses;
    conv_req = 1'b1;
    @(negedge clk);
    conv_req = 1'b0;
    for (int i = 0; i < 6 && n_pulses == p0; i++) @(negedge clk);
    chk("R1 accept", n_pulses == p0 + 1, n_pulses - p0, 1);
    cycles(2);
    adc_busy = 1'b0;
    cycles(3);
    for (int i = 0; i < edges; i++) begin
      adc_sdata = (i < 12) ? w[11-i] : 1'($urandom);
      cycles(2);
      adc_dclk = 1'b1;
      cycles(4);
      adc_dclk = 1'b0;
      cycles(2);
      if (poke_busy && i == 3) begin
        conv_req = 1'b1;
        @(negedge clk);
        conv_req = 1'b0;
      end
    end
    if (poke_busy && edges < 4) begin
      conv_req = 1'b1;
      @(negedge clk);
      conv_req = 1'b0;
    end
    cycles(4);
    adc_busy = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (smp_valid) begin got_v++; d = smp_data; ix = smp_index; end
      if (frame_err) got_e++;
    end
    chk("R1 width", last_w == PULSE, last_w, PULSE);
    if (poke_busy)
      chk("R2 busy-low request dropped", n_pulses == p0 + 1, n_pulses - p0, 1);
    if (conv_k == 0) begin
      chk("R7 first valid", got_v == 0, got_v, 0);
      chk("R7 first err", got_e == 0, got_e, 0);
    end else if (edges == 12) begin
      chk("R5 valid count", got_v == 1, got_v, 1);
      chk("R4 data", d == exp_sample(w), int'(d), int'(exp_sample(w)));
      chk("R6 index", ix == exp_index(conv_k), int'(ix), int'(exp_index(conv_k)));
      chk("R8 no err on good", got_e == 0, got_e, 0);
    end else begin
      chk("R8 err count", got_e == 1, got_e, 1);
      chk("R8 no valid", got_v == 0, got_v, 0);
    end
    conv_k++;
  endtask

  initial begin
    int e;
    void'($urandom(32'h5eed_1234));
    cycles(3);
    // R9: reset state
    chk("R9 conv_n", adc_conv_n == 1'b1, adc_conv_n, 1);
    chk("R9 valid", smp_valid == 1'b0, smp_valid, 0);
    chk("R9 err", frame_err == 1'b0, frame_err, 0);
    chk("R9 data", smp_data == '0, int'(smp_data), 0);
    chk("R9 index", smp_index == '0, int'(smp_index), 0);
    rst_n = 1'b1;
    cycles(3);

    burst(12, 12'h5A3, 1'b0);        // R7: first burst discarded
    burst(12, 12'h800, 1'b0);        // R4: most negative
    burst(12, 12'h7FF, 1'b1);        // R4 extreme, R2 poke during busy low

    // R3: request right after completion, inside the spacing window
    begin
      int p0;
      p0 = n_pulses;
      conv_req = 1'b1;
      @(negedge clk);
      conv_req = 1'b0;
      cycles(10);
      chk("R3 early request dropped", n_pulses == p0, n_pulses - p0, 0);
      chk("R2 dropped request not queued", adc_conv_n == 1'b1, adc_conv_n, 1);
    end

    burst(0, 12'h000, 1'b0);         // R8: empty burst
    burst(12, 12'h001, 1'b0);        // R6: index after a lost sample

    // R10: stray data clock edges with data high while idle
    adc_sdata = 1'b1;
    for (int i = 0; i < 5; i++) begin
      adc_dclk = 1'b1; cycles(4); adc_dclk = 1'b0; cycles(4);
    end
    chk("R10 idle edges no pulse", smp_valid == 1'b0 && frame_err == 1'b0, smp_valid, 0);
    burst(12, 12'h0F0, 1'b0);        // R10: word unaffected

    // Seeded random mix of good and bad bursts
    for (int n = 0; n < 30; n++) begin
      e = 12;
      if ($urandom_range(0, 4) == 0) e = ($urandom_range(0, 1) == 0) ? 11 : 13;
      burst(e, 12'($urandom), 1'b0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

endmodule